// File: doc/BRIEF.md
# Message Register Handshake Controller

This block holds a pair of 16-bit message registers, one high and one low, that two agents share: a local processor port and a remote bus port. Either port can read or write either register, one byte lane at a time or both together. Four handshake flags travel with the registers: read-ready (outgoing data waits for the far side), write-ready (the registers may take a new incoming message), lock, and alternate-busy. Those flags change as side effects of particular accesses, so a word-serial message protocol can run with plain loads and stores and no separate command path.

The local side raises flags by writing a control register. The flags drop when the registers are touched: reading the low word drops read-ready, writing the low byte of the low word drops write-ready, any access to the low byte of the high word drops alternate-busy, and reading the alternate response register drops the lock only while write-ready is up. A 16-bit message is a single low-word write. A 32-bit message writes the high word first and the low word last, so only the final write ends the message. When read-ready or write-ready falls, a pending message interrupt is latched and shown active-low. Reading the interrupt status register clears it.

Read data is combinational and shows the state before the access. Side effects take hold at the clock edge that ends the access.

Top module: `mbx_msg_ctrl`

## Requirements
- R1: After reset all four flags read 0, both message registers read 0, the interrupt status reads 1 and msg_irq_n is 1.
- R2: A write to select 0 (high word) or select 1 (low word) updates only the byte lanes whose enable is set (be[0] = bits 7:0, be[1] = bits 15:8). Either port can read the result back. When both ports write the same lane in one cycle, the local data is stored.
- R3: A local write to select 3 with be[0] set raises each flag whose data bit is 1: bit 0 read-ready, bit 1 write-ready, bit 2 lock, bit 3 alternate-busy. Data bits that are 0 change nothing, and remote writes to select 3 change no flag.
- R4: Any read of select 1 by either port clears read-ready.
- R5: A write to select 1 with be[0] set clears write-ready. A write with only be[1] set leaves it unchanged, so writing the high word before the low word keeps the message open.
- R6: A read or write of select 0 with be[0] set clears alternate-busy. An access with only be[1] set leaves it unchanged.
- R7: A read of select 2 clears the lock when write-ready is 1 and leaves it unchanged when write-ready is 0.
- R8: When a local flag-raising write and a clearing access hit the same flag in one cycle, the flag ends up 1.
- R9: A falling read-ready or write-ready latches a pending interrupt. msg_irq_n goes 0 and bit 0 of select 4 reads 0 (active-low). A read of select 4 clears it, unless a new fall happens in the same cycle, in which case the interrupt stays pending.
- R10: Reads of selects 2 and 3 return {12'b0, alternate-busy, lock, write-ready, read-ready}. Select 4 returns {15'b0, status}. Unused selects, writes and idle ports return 0 on rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_stb | input | 1 | Local access strobe, one cycle per access |
| loc_wr | input | 1 | Local access is a write |
| loc_sel | input | 3 | Local register select |
| loc_be | input | 2 | Local byte-lane enables |
| loc_wdata | input | 16 | Local write data |
| loc_rdata | output | 16 | Local read data |
| rem_stb | input | 1 | Remote access strobe |
| rem_wr | input | 1 | Remote access is a write |
| rem_sel | input | 3 | Remote register select |
| rem_be | input | 2 | Remote byte-lane enables |
| rem_wdata | input | 16 | Remote write data |
| rem_rdata | output | 16 | Remote read data |
| msg_irq_n | output | 1 | Message interrupt, active-low |

## Verification
Two functions can land on the same edge. The first is a flag being raised by a local control write while the remote port reads the low word, which would clear it. The second is the interrupt status being read and cleared while a flag falls and sets it again. The bench provokes both by driving the two ports in one cycle. It judges them from the flag word and msg_irq_n on the following cycle: read-ready must stay 1 with no interrupt in the first case, and the interrupt must stay pending in the second.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W = 16;
  localparam int BYTES  = DATA_W / 8;
  localparam int SEL_W  = 3;

  typedef logic [SEL_W-1:0] sel_t;
  localparam sel_t SEL_HI  = 3'd0;
  localparam sel_t SEL_LO  = 3'd1;
  localparam sel_t SEL_ALT = 3'd2;
  localparam sel_t SEL_CTL = 3'd3;
  localparam sel_t SEL_IRQ = 3'd4;

  typedef struct packed {
    logic abmh;
    logic mlck;
    logic wrdy;
    logic rrdy;
  } flags_t;

  typedef struct packed {
    logic rd_lo;
    logic wr_lo_b0;
    logic hi_b0;
    logic rd_alt;
    logic rd_irq;
  } port_ev_t;

  function automatic logic [DATA_W-1:0] flag_word(input flags_t f);
    return {{(DATA_W-4){1'b0}}, f};
  endfunction

  function automatic logic [DATA_W-1:0] read_mux(
    input logic stb, input logic wr, input sel_t sel,
    input logic [DATA_W-1:0] hi, input logic [DATA_W-1:0] lo,
    input flags_t f, input logic pend);
    logic [DATA_W-1:0] r;
    r = '0;
    if (stb && !wr) begin
      case (sel)
        SEL_HI:  r = hi;
        SEL_LO:  r = lo;
        SEL_ALT: r = flag_word(f);
        SEL_CTL: r = flag_word(f);
        SEL_IRQ: r = {{(DATA_W-1){1'b0}}, ~pend};
        default: r = '0;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
  import mbx_pkg::*;
(
  input  logic             stb,
  input  logic             wr,
  input  sel_t             sel,
  input  logic [BYTES-1:0] be,
  output port_ev_t         ev,
  output logic [BYTES-1:0] hi_we,
  output logic [BYTES-1:0] lo_we
);
  logic is_rd, is_wr;
  assign is_rd = stb && !wr;
  assign is_wr = stb && wr;

  always_comb begin
    ev.rd_lo    = is_rd && (sel == SEL_LO);
    ev.wr_lo_b0 = is_wr && (sel == SEL_LO) && be[0];
    ev.hi_b0    = stb && (sel == SEL_HI) && be[0];
    ev.rd_alt   = is_rd && (sel == SEL_ALT);
    ev.rd_irq   = is_rd && (sel == SEL_IRQ);
    hi_we       = (is_wr && sel == SEL_HI) ? be : '0;
    lo_we       = (is_wr && sel == SEL_LO) ? be : '0;
  end
endmodule

// File: rtl/mbx_store.sv
module mbx_store
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTES-1:0]  loc_hi_we,
  input  logic [BYTES-1:0]  loc_lo_we,
  input  logic [BYTES-1:0]  rem_hi_we,
  input  logic [BYTES-1:0]  rem_lo_we,
  input  logic [DATA_W-1:0] loc_wdata,
  input  logic [DATA_W-1:0] rem_wdata,
  output logic [DATA_W-1:0] msg_hi,
  output logic [DATA_W-1:0] msg_lo
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        msg_hi[b*8 +: 8] <= '0;
        msg_lo[b*8 +: 8] <= '0;
      end else begin
        if (loc_hi_we[b])      msg_hi[b*8 +: 8] <= loc_wdata[b*8 +: 8];
        else if (rem_hi_we[b]) msg_hi[b*8 +: 8] <= rem_wdata[b*8 +: 8];
        if (loc_lo_we[b])      msg_lo[b*8 +: 8] <= loc_wdata[b*8 +: 8];
        else if (rem_lo_we[b]) msg_lo[b*8 +: 8] <= rem_wdata[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags
  import mbx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  flags_t   set_req,
  input  port_ev_t loc_ev,
  input  port_ev_t rem_ev,
  output flags_t   flags,
  output flags_t   clr_req,
  output logic     rrdy_fall,
  output logic     wrdy_fall
);
  flags_t nxt;

  always_comb begin
    clr_req.rrdy = loc_ev.rd_lo | rem_ev.rd_lo;
    clr_req.wrdy = loc_ev.wr_lo_b0 | rem_ev.wr_lo_b0;
    clr_req.abmh = loc_ev.hi_b0 | rem_ev.hi_b0;
    clr_req.mlck = (loc_ev.rd_alt | rem_ev.rd_alt) & flags.wrdy;
    nxt = set_req | (flags & ~clr_req);
  end

  assign rrdy_fall = flags.rrdy & ~nxt.rrdy;
  assign wrdy_fall = flags.wrdy & ~nxt.wrdy;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter bit IRQ_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_any,
  input  logic ack,
  output logic pend
);
  if (IRQ_EN) begin : g_irq
    always_ff @(posedge clk) begin
      if (!rst_n)        pend <= 1'b0;
      else if (fall_any) pend <= 1'b1;
      else if (ack)      pend <= 1'b0;
    end
  end else begin : g_noirq
    logic unused;
    assign unused = fall_any ^ ack ^ clk ^ rst_n;
    assign pend = 1'b0;
  end
endmodule

// File: rtl/mbx_msg_ctrl.sv
module mbx_msg_ctrl
  import mbx_pkg::*;
#(
  parameter bit IRQ_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_stb,
  input  logic              loc_wr,
  input  logic [SEL_W-1:0]  loc_sel,
  input  logic [BYTES-1:0]  loc_be,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic [DATA_W-1:0] loc_rdata,
  input  logic              rem_stb,
  input  logic              rem_wr,
  input  logic [SEL_W-1:0]  rem_sel,
  input  logic [BYTES-1:0]  rem_be,
  input  logic [DATA_W-1:0] rem_wdata,
  output logic [DATA_W-1:0] rem_rdata,
  output logic              msg_irq_n
);
  port_ev_t          loc_ev, rem_ev;
  logic [BYTES-1:0]  loc_hi_we, loc_lo_we, rem_hi_we, rem_lo_we;
  logic [DATA_W-1:0] msg_hi, msg_lo;
  flags_t            flags, set_req, clr_req;
  logic              rrdy_fall, wrdy_fall, irq_pend, irq_ack;

  mbx_port_dec u_loc_dec (
    .stb(loc_stb), .wr(loc_wr), .sel(loc_sel), .be(loc_be),
    .ev(loc_ev), .hi_we(loc_hi_we), .lo_we(loc_lo_we)
  );

  mbx_port_dec u_rem_dec (
    .stb(rem_stb), .wr(rem_wr), .sel(rem_sel), .be(rem_be),
    .ev(rem_ev), .hi_we(rem_hi_we), .lo_we(rem_lo_we)
  );

  assign set_req = (loc_stb && loc_wr && loc_sel == SEL_CTL && loc_be[0])
                 ? flags_t'(loc_wdata[3:0]) : '0;

  mbx_store u_store (
    .clk(clk), .rst_n(rst_n),
    .loc_hi_we(loc_hi_we), .loc_lo_we(loc_lo_we),
    .rem_hi_we(rem_hi_we), .rem_lo_we(rem_lo_we),
    .loc_wdata(loc_wdata), .rem_wdata(rem_wdata),
    .msg_hi(msg_hi), .msg_lo(msg_lo)
  );

  mbx_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_req(set_req),
    .loc_ev(loc_ev), .rem_ev(rem_ev), .flags(flags), .clr_req(clr_req),
    .rrdy_fall(rrdy_fall), .wrdy_fall(wrdy_fall)
  );

  assign irq_ack = loc_ev.rd_irq | rem_ev.rd_irq;

  mbx_irq #(.IRQ_EN(IRQ_EN)) u_irq (
    .clk(clk), .rst_n(rst_n), .fall_any(rrdy_fall | wrdy_fall),
    .ack(irq_ack), .pend(irq_pend)
  );

  assign loc_rdata = read_mux(loc_stb, loc_wr, loc_sel, msg_hi, msg_lo, flags, irq_pend);
  assign rem_rdata = read_mux(rem_stb, rem_wr, rem_sel, msg_hi, msg_lo, flags, irq_pend);
  assign msg_irq_n = ~irq_pend;

  logic unused_hi;
  assign unused_hi = ^loc_wdata[DATA_W-1:4] ^ ^clr_req;
endmodule

// File: rtl/mbx_msg_ctrl_chk.sv
module mbx_msg_ctrl_chk
  import mbx_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input port_ev_t loc_ev,
  input port_ev_t rem_ev,
  input flags_t   set_req,
  input flags_t   flags,
  input logic     msg_irq_n
);
  AST_RRDY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((loc_ev.rd_lo || rem_ev.rd_lo) && !set_req.rrdy) |=> !flags.rrdy); // R4
  AST_WRDY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((loc_ev.wr_lo_b0 || rem_ev.wr_lo_b0) && !set_req.wrdy) |=> !flags.wrdy); // R5
  AST_ABMH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((loc_ev.hi_b0 || rem_ev.hi_b0) && !set_req.abmh) |=> !flags.abmh); // R6
  AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags.wrdy && !set_req.mlck) |=> (flags.mlck == $past(flags.mlck))); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_req.rrdy |=> flags.rrdy); // R8
  AST_FALL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flags.rrdy) || $fell(flags.wrdy)) |-> !msg_irq_n); // R9
endmodule

bind mbx_msg_ctrl mbx_msg_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .loc_ev(loc_ev), .rem_ev(rem_ev),
  .set_req(set_req), .flags(flags), .msg_irq_n(msg_irq_n)
);

// File: tb/sim_mbx_msg_ctrl.sv
module sim_mbx_msg_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loc_stb = 0, loc_wr = 0, rem_stb = 0, rem_wr = 0;
  logic [2:0]  loc_sel = 0, rem_sel = 0;
  logic [1:0]  loc_be = 0, rem_be = 0;
  logic [15:0] loc_wdata = 0, rem_wdata = 0;
  logic [15:0] loc_rdata, rem_rdata;
  logic        msg_irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          rem;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  mbx_msg_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .loc_stb(loc_stb), .loc_wr(loc_wr), .loc_sel(loc_sel), .loc_be(loc_be),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
    .rem_stb(rem_stb), .rem_wr(rem_wr), .rem_sel(rem_sel), .rem_be(rem_be),
    .rem_wdata(rem_wdata), .rem_rdata(rem_rdata), .msg_irq_n(msg_irq_n)
  );

  // monitor: pops expected read data and compares mid low phase
  always @(negedge clk) begin
    #3;
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      act = it.rem ? rem_rdata : loc_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic idle_all();
    loc_stb = 0; loc_wr = 0; rem_stb = 0; rem_wr = 0;
  endtask

  task automatic set_port(bit rem, bit stb, bit wr, logic [2:0] sel,
                          logic [1:0] be, logic [15:0] d);
    if (rem) begin
      rem_stb = stb; rem_wr = wr; rem_sel = sel; rem_be = be; rem_wdata = d;
    end else begin
      loc_stb = stb; loc_wr = wr; loc_sel = sel; loc_be = be; loc_wdata = d;
    end
  endtask

  task automatic wr(bit rem, logic [2:0] sel, logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    idle_all();
    set_port(rem, 1, 1, sel, be, d);
  endtask

  task automatic rd(bit rem, logic [2:0] sel, logic [1:0] be,
                    logic [15:0] exp, string tag);
    @(negedge clk);
    idle_all();
    set_port(rem, 1, 0, sel, be, 16'h0);
    sb.push_back('{rem, exp, tag});
  endtask

  task automatic chk_irq(logic exp, string tag);
    @(negedge clk);
    idle_all();
    #3;
    checks++;
    if (msg_irq_n !== exp) begin
      errors++;
      $display("FAIL %s irq_n actual %b expected %b", tag, msg_irq_n, exp);
    end
  endtask

  task automatic chk_idle(string tag);
    @(negedge clk);
    idle_all();
    #3;
    checks++;
    if (loc_rdata !== 16'h0 || rem_rdata !== 16'h0) begin
      errors++;
      $display("FAIL %s idle rdata actual %h/%h expected 0000", tag, loc_rdata, rem_rdata);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, 3'd3, 2'b11, 16'h0000, "R1 flags");
    rd(1, 3'd4, 2'b11, 16'h0001, "R1 irq status");
    rd(0, 3'd0, 2'b11, 16'h0000, "R1 high word");
    rd(1, 3'd1, 2'b01, 16'h0000, "R1 low word");
    chk_irq(1'b1, "R1");
    // R3 remote control writes ignored, local sets, zeros no effect
    wr(1, 3'd3, 2'b11, 16'h000F);
    rd(0, 3'd3, 2'b11, 16'h0000, "R3 remote set ignored");
    wr(0, 3'd3, 2'b01, 16'h0005);
    rd(0, 3'd3, 2'b11, 16'h0005, "R3 local set");
    wr(0, 3'd3, 2'b01, 16'h0000);
    rd(0, 3'd3, 2'b11, 16'h0005, "R3 zero bits");
    wr(0, 3'd3, 2'b01, 16'h000A);
    rd(1, 3'd3, 2'b11, 16'h000F, "R3 all set");
    // R6 alternate-busy
    wr(0, 3'd0, 2'b10, 16'h5600);
    rd(0, 3'd3, 2'b11, 16'h000F, "R6 upper lane write");
    rd(1, 3'd0, 2'b10, 16'h5600, "R2 high readback");
    rd(0, 3'd3, 2'b11, 16'h000F, "R6 upper lane read");
    rd(1, 3'd0, 2'b01, 16'h5600, "R2 high readback low lane");
    rd(0, 3'd3, 2'b11, 16'h0007, "R6 low lane read clears");
    // R2 lane merge from remote
    wr(1, 3'd0, 2'b01, 16'hFF34);
    rd(0, 3'd0, 2'b11, 16'h5634, "R2 lane merge");
    // R5 write-ready, 32-bit ordering
    wr(0, 3'd1, 2'b10, 16'hAB00);
    rd(0, 3'd3, 2'b11, 16'h0007, "R5 upper lane keeps");
    chk_irq(1'b1, "R9 no fall");
    wr(1, 3'd1, 2'b01, 16'h00CD);
    rd(0, 3'd3, 2'b11, 16'h0005, "R5 low lane clears");
    chk_irq(1'b0, "R9 wrdy fall");
    rd(1, 3'd4, 2'b11, 16'h0000, "R9 status pending");
    chk_irq(1'b1, "R9 cleared by read");
    rd(0, 3'd4, 2'b11, 16'h0001, "R9 status idle");
    // R7 lock
    rd(1, 3'd2, 2'b11, 16'h0005, "R10 alt word");
    rd(0, 3'd3, 2'b11, 16'h0005, "R7 lock kept");
    wr(0, 3'd3, 2'b01, 16'h0002);
    rd(1, 3'd2, 2'b11, 16'h0007, "R10 alt word wrdy");
    rd(0, 3'd3, 2'b11, 16'h0003, "R7 lock cleared");
    // R4 read-ready
    rd(1, 3'd1, 2'b11, 16'hABCD, "R2 low readback");
    rd(0, 3'd3, 2'b11, 16'h0002, "R4 low read clears");
    chk_irq(1'b0, "R9 rrdy fall");
    rd(0, 3'd4, 2'b11, 16'h0000, "R9 status pending local");
    // R8 set beats clear in one cycle
    @(negedge clk);
    idle_all();
    set_port(0, 1, 1, 3'd3, 2'b01, 16'h0001);
    set_port(1, 1, 0, 3'd1, 2'b11, 16'h0);
    sb.push_back('{1'b1, 16'hABCD, "R2 low read during set"});
    rd(0, 3'd3, 2'b11, 16'h0003, "R8 rrdy stays set");
    chk_irq(1'b1, "R8 no interrupt");
    // R9 status read and new fall together
    @(negedge clk);
    idle_all();
    set_port(0, 1, 0, 3'd4, 2'b11, 16'h0);
    set_port(1, 1, 0, 3'd1, 2'b11, 16'h0);
    sb.push_back('{1'b0, 16'h0001, "R9 status before fall"});
    sb.push_back('{1'b1, 16'hABCD, "R2 low read"});
    chk_irq(1'b0, "R9 fall beats ack");
    rd(0, 3'd3, 2'b11, 16'h0002, "R4 cleared in dual cycle");
    rd(0, 3'd4, 2'b11, 16'h0000, "R9 ack");
    // R2 collisions
    @(negedge clk);
    idle_all();
    set_port(0, 1, 1, 3'd1, 2'b11, 16'h1111);
    set_port(1, 1, 1, 3'd1, 2'b11, 16'h2222);
    rd(1, 3'd1, 2'b11, 16'h1111, "R2 local wins");
    @(negedge clk);
    idle_all();
    set_port(0, 1, 1, 3'd0, 2'b01, 16'h00AA);
    set_port(1, 1, 1, 3'd0, 2'b10, 16'hBB00);
    rd(0, 3'd0, 2'b11, 16'hBBAA, "R2 split lanes");
    // R10 unused select, write and idle
    rd(0, 3'd5, 2'b11, 16'h0000, "R10 unused select");
    @(negedge clk);
    idle_all();
    set_port(1, 1, 1, 3'd7, 2'b11, 16'hFFFF);
    sb.push_back('{1'b1, 16'h0000, "R10 write returns zero"});
    chk_idle("R10");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule